// File: doc/BRIEF.md
# Write-Back Buffer with Snoop Lookup

This block is a small queue of dirty cache lines. Each line waits here after eviction until lower memory has accepted the write and confirmed it. The cache eviction path offers one line per cycle, as an address, a data word and a dirty flag. Only dirty lines are stored. The buffer sends each stored line to memory exactly once, oldest first, over a valid/ready write port. It keeps the line until a separate acknowledge pulse retires it.

While a line waits, the miss handler can look it up by address through a combinational lookup port. On a hit the port returns the stored data. The miss handler then serves the miss from that data and does not fetch the line from memory. The lookup covers lines that were already sent but are not yet acknowledged. When two stored lines share an address, the more recent one answers.

The full flag tells the cache to stall any request that would cause an eviction. One exception applies: in a cycle where an acknowledge frees a slot, a full buffer still accepts the eviction.

Top module: `wb_snoop_buf`

## Requirements
- R1: An eviction is stored only when `evict_valid_i` and `evict_dirty_i` are both 1. An eviction with `evict_dirty_i` = 0 changes no output, and its line never appears on the write port.
- R2: `full_o` is 1 exactly when `DEPTH` lines are held, and 0 after reset.
- R3: An eviction offered while `full_o` is 1 and no acknowledge is taken in that cycle is dropped.
- R4: An eviction offered while `full_o` is 1, in the same cycle as an accepted acknowledge, is stored.
- R5: `mem_wvalid_o` is 1 whenever a held line has not yet been sent. `mem_waddr_o` and `mem_wdata_o` then show the oldest unsent line, in the order the lines were stored.
- R6: A line counts as sent only in a cycle where `mem_wvalid_o` and `mem_wready_i` are both 1. While `mem_wready_i` is 0, the write port holds its address and data.
- R7: Each stored line is presented on the write port and sent once only.
- R8: `mem_ack_i` retires the oldest sent line. A line leaves the buffer only through an acknowledge. An acknowledge while no sent line is outstanding is ignored.
- R9: `lookup_hit_o` is 1 in the same cycle when `lookup_addr_i` equals the address of any held line, sent or not. `lookup_data_o` then carries that line's data.
- R10: When several held lines match the lookup address, the data returned is that of the most recently stored one.
- R11: An active-low reset, asynchronous, empties the buffer. `full_o`, `mem_wvalid_o` and `lookup_hit_o` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Eviction offered this cycle |
| evict_dirty_i | input | 1 | Evicted line was modified |
| evict_addr_i | input | ADDR_W | Evicted line address |
| evict_data_i | input | DATA_W | Evicted line data |
| full_o | output | 1 | All slots occupied |
| mem_wvalid_o | output | 1 | Write request pending |
| mem_wready_i | input | 1 | Memory accepts the write this cycle |
| mem_waddr_o | output | ADDR_W | Write address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory completed the oldest sent write |
| lookup_addr_i | input | ADDR_W | Address looked up by the miss handler |
| lookup_hit_o | output | 1 | A held line matches |
| lookup_data_o | output | DATA_W | Data of the youngest matching line |

## Verification
The hardest state to reach from the ports is a full buffer that receives, in one cycle, an acknowledge and a new eviction whose slot is the one being retired. The same state must also hold an older copy of the same address, so that the youngest-match rule and slot reuse are tested together. The stimulus reaches it directly. It fills the buffer with memory ready held low and uses duplicate addresses. It then lets two writes go out, and sends acknowledges together with further dirty evictions while still full. A long phase follows with random ready, acknowledge and eviction traffic over a handful of addresses. It ends with a reset in the middle of traffic.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int unsigned WBB_DEPTH  = 4;
  localparam int unsigned WBB_ADDR_W = 16;
  localparam int unsigned WBB_DATA_W = 32;
endpackage

// File: rtl/wbb_ctrl.sv
module wbb_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_req_i,
  input  logic             wready_i,
  input  logic             ack_i,
  output logic             full_o,
  output logic             wvalid_o,
  output logic             enq_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] iss_idx_o,
  output logic [DEPTH-1:0] valid_o
);
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [PTR_W:0]   cnt_q, iss_cnt_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [DEPTH-1:0] valid_q, issued_q;
  logic             ack_ok, fire;

  assign full_o    = (cnt_q == FULL_CNT);
  assign ack_ok    = ack_i && (iss_cnt_q != '0);
  assign wvalid_o  = (cnt_q > iss_cnt_q);
  assign fire      = wvalid_o && wready_i;
  // a slot freed by this cycle's ack may be refilled at once
  assign enq_o     = enq_req_i && (!full_o || ack_ok);
  assign iss_idx_o = head_q + iss_cnt_q[PTR_W-1:0];
  assign tail_o    = tail_q;
  assign head_o    = head_q;
  assign valid_o   = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      iss_cnt_q <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      valid_q   <= '0;
      issued_q  <= '0;
    end else begin
      if (ack_ok) begin
        valid_q[head_q]  <= 1'b0;
        issued_q[head_q] <= 1'b0;
        head_q           <= head_q + 1'b1;
      end
      if (fire) issued_q[iss_idx_o] <= 1'b1;
      if (enq_o) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= tail_q + 1'b1;
      end
      cnt_q     <= cnt_q + {{PTR_W{1'b0}}, enq_o} - {{PTR_W{1'b0}}, ack_ok};
      iss_cnt_q <= iss_cnt_q + {{PTR_W{1'b0}}, fire} - {{PTR_W{1'b0}}, ack_ok};
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !ack_i |=> full_o);
  a_r8_free_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q >= $past(cnt_q)) || $past(ack_i));
  a_r7_send_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> valid_q[iss_idx_o] && !issued_q[iss_idx_o]);
endmodule

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic [PTR_W-1:0]              wr_idx_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [PTR_W-1:0]              rd_idx_i,
  output logic [ADDR_W-1:0]             rd_addr_o,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_tab_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_tab_o
);
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      addr_q[wr_idx_i] <= wr_addr_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_addr_o  = addr_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
  assign addr_tab_o = addr_q;
  assign data_tab_o = data_q;
endmodule

// File: rtl/wbb_snoop.sv
module wbb_snoop #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0]            lookup_addr_i,
  input  logic [PTR_W-1:0]             head_i,
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_tab_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_tab_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            data_o
);
  // scan oldest to youngest; later matches override, so the youngest wins
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] idx;
      idx = head_i + PTR_W'(k);
      if (valid_i[idx] && (addr_tab_i[idx] == lookup_addr_i)) begin
        hit_o  = 1'b1;
        data_o = data_tab_i[idx];
      end
    end
  end
endmodule

// File: rtl/wb_snoop_buf.sv
module wb_snoop_buf
  import wbb_pkg::*;
#(
  parameter int unsigned DEPTH  = WBB_DEPTH,
  parameter int unsigned ADDR_W = WBB_ADDR_W,
  parameter int unsigned DATA_W = WBB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic              evict_dirty_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  output logic              full_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic [DATA_W-1:0] lookup_data_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic                         enq;
  logic [PTR_W-1:0]             tail, head, iss_idx;
  logic [DEPTH-1:0]             valid;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_tab;
  logic [DEPTH-1:0][DATA_W-1:0] data_tab;

  wbb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enq_req_i (evict_valid_i && evict_dirty_i),
    .wready_i  (mem_wready_i),
    .ack_i     (mem_ack_i),
    .full_o    (full_o),
    .wvalid_o  (mem_wvalid_o),
    .enq_o     (enq),
    .tail_o    (tail),
    .head_o    (head),
    .iss_idx_o (iss_idx),
    .valid_o   (valid)
  );

  wbb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i      (clk_i),
    .wr_en_i    (enq),
    .wr_idx_i   (tail),
    .wr_addr_i  (evict_addr_i),
    .wr_data_i  (evict_data_i),
    .rd_idx_i   (iss_idx),
    .rd_addr_o  (mem_waddr_o),
    .rd_data_o  (mem_wdata_o),
    .addr_tab_o (addr_tab),
    .data_tab_o (data_tab)
  );

  wbb_snoop #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_snoop (
    .lookup_addr_i (lookup_addr_i),
    .head_i        (head),
    .valid_i       (valid),
    .addr_tab_i    (addr_tab),
    .data_tab_i    (data_tab),
    .hit_o         (lookup_hit_o),
    .data_o        (lookup_data_o)
  );

  a_r6_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wvalid_o && !mem_wready_i |=>
      mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o));
  a_r9_hit_needs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> valid != '0);
  a_r1_clean_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && !evict_dirty_i && !mem_ack_i && !mem_wvalid_o |=> !mem_wvalid_o);
endmodule

// File: tb/test_wb_snoop_buf.sv
module test_wb_snoop_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, AW = 16, DW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic evict_valid, evict_dirty, mem_wready, mem_ack;
  logic [AW-1:0] evict_addr, lookup_addr, mem_waddr;
  logic [DW-1:0] evict_data, mem_wdata, lookup_data;
  logic full, mem_wvalid, lookup_hit;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wb_snoop_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_wb_snoop_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evict_valid_i(evict_valid), .evict_dirty_i(evict_dirty),
    .evict_addr_i(evict_addr), .evict_data_i(evict_data),
    .full_o(full), .mem_wvalid_o(mem_wvalid), .mem_wready_i(mem_wready),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .lookup_addr_i(lookup_addr), .lookup_hit_o(lookup_hit), .lookup_data_o(lookup_data)
  );

  // behavioural model
  logic [AW-1:0] q_a[$];
  logic [DW-1:0] q_d[$];
  int n_iss = 0;
  int compared = 0, mismatched = 0;
  string phase = "reset";

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s (%s) actual=%0h expected=%0h", req, what, phase, act, expv);
    end
  endtask

  task automatic compare();
    bit e_full, e_wv, e_hit;
    int found;
    e_full = (q_a.size() == DEPTH);
    e_wv   = (q_a.size() > n_iss);
    chk(full == e_full, "R2", "full_o", full, e_full);
    chk(mem_wvalid == e_wv, "R5", "mem_wvalid_o", mem_wvalid, e_wv);
    if (e_wv && mem_wvalid) begin
      chk(mem_waddr == q_a[n_iss], "R5", "mem_waddr_o", mem_waddr, q_a[n_iss]);
      chk(mem_wdata == q_d[n_iss], "R7", "mem_wdata_o", mem_wdata, q_d[n_iss]);
    end
    found = -1;
    foreach (q_a[i]) if (q_a[i] == lookup_addr) found = i;
    e_hit = (found >= 0);
    chk(lookup_hit == e_hit, "R9", "lookup_hit_o", lookup_hit, e_hit);
    if (e_hit && lookup_hit)
      chk(lookup_data == q_d[found], "R10", "lookup_data_o", lookup_data, q_d[found]);
  endtask

  task automatic step(bit ev, bit dirty, logic [AW-1:0] a, logic [DW-1:0] d,
                      bit rdy, bit ack, logic [AW-1:0] lk);
    bit ack_ok, fire, enq;
    evict_valid = ev; evict_dirty = dirty; evict_addr = a; evict_data = d;
    mem_wready = rdy; mem_ack = ack; lookup_addr = lk;
    #1;
    compare();
    ack_ok = ack && (n_iss > 0);
    fire   = (q_a.size() > n_iss) && rdy;
    enq    = ev && dirty && ((q_a.size() < DEPTH) || ack_ok);
    @(posedge clk_i);
    if (ack_ok) begin void'(q_a.pop_front()); void'(q_d.pop_front()); n_iss--; end
    if (fire) n_iss++;
    if (enq) begin q_a.push_back(a); q_d.push_back(d); end
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    evict_valid = 0; evict_dirty = 0; evict_addr = '0; evict_data = '0;
    mem_wready = 0; mem_ack = 0; lookup_addr = '0;
    @(negedge clk_i); #1;
    phase = "R11 in reset"; compare();
    @(negedge clk_i); rst_ni = 1'b1;

    phase = "R1 clean evictions dropped";
    for (int i = 0; i < 3; i++) step(1, 0, 16'h0100 + 16'(i), 32'hC0DE0000 + 32'(i), 1, 0, 16'h0100 + 16'(i));
    step(0, 0, 0, 0, 1, 0, 16'h0101);

    phase = "R2 fill with duplicates";
    step(1, 1, 16'h0010, 32'hA0, 0, 0, 16'h0010);
    step(1, 1, 16'h0020, 32'hA1, 0, 0, 16'h0010);
    step(1, 1, 16'h0010, 32'hA2, 0, 0, 16'h0010);
    step(1, 1, 16'h0030, 32'hA3, 0, 0, 16'h0010);
    phase = "R3 full drop without ack";
    step(1, 1, 16'h0040, 32'hA4, 0, 1, 16'h0040);
    step(0, 0, 0, 0, 0, 0, 16'h0040);
    phase = "R6 stalled write held";
    step(0, 0, 0, 0, 0, 0, 16'h0020);
    phase = "R7 send two";
    step(0, 0, 0, 0, 1, 0, 16'h0010);
    step(0, 0, 0, 0, 1, 0, 16'h0030);
    phase = "R4 full ack plus evict";
    step(1, 1, 16'h0010, 32'hB0, 0, 1, 16'h0010);
    step(0, 0, 0, 0, 0, 0, 16'h0010);
    step(1, 1, 16'h0050, 32'hB1, 0, 1, 16'h0050);
    step(0, 0, 0, 0, 0, 0, 16'h0020);
    phase = "R8 drain and spurious ack";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 1, 16'h0010);
    step(0, 0, 0, 0, 0, 1, 16'h0010);
    step(0, 0, 0, 0, 0, 1, 16'h0050);

    phase = "R10 random traffic";
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           16'h0200 + 16'($urandom_range(0, 5)), $urandom,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           16'h0200 + 16'($urandom_range(0, 6)));

    phase = "R11 reset mid traffic";
    for (int i = 0; i < 3; i++) step(1, 1, 16'h0300 + 16'(i), 32'(i), 0, 0, 16'h0300);
    rst_ni = 1'b0;
    q_a.delete(); q_d.delete(); n_iss = 0;
    #1; compare();
    @(negedge clk_i); rst_ni = 1'b1;
    step(0, 0, 0, 0, 1, 1, 16'h0300);
    step(0, 0, 0, 0, 1, 0, 16'h0301);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule